// File: doc/BRIEF.md
# Cascadable LCD Segment Line Driver

This block is the digital core of a column driver for a passive dot-matrix panel. A controller sends one display line, a few pixels at a time, over a parallel bus whose width can be eight or four lines. Each transfer goes into a capture buffer. When a load strobe falls, the whole captured line moves to an output latch. Every output then shows a two-bit drive-level code. That code depends on the latched pixel bit, the frame alternation phase and a blanking input.

Several identical drivers can share one bus. An active-low enable chain passes the right to accept data from one driver to the next. A driver stops listening once its own part of the row is full and pulls its enable output low, which lets the next driver start. A direction input sets the bit order inside each transfer group. It also decides which of the two enable pins listens and which one drives. Each enable pin is modelled as an input, an output and an output-enable.

Top module: `seg_line_driver`

## Requirements
- R1: After reset the enable output is high, the transfer count is zero and the output latch holds all zeros. With alternation high and display on, every output code is 2'b01.
- R2: With `wide` high, a line is complete after 20 accepted transfers of 8 bits. Transfer k (counting from 0) fills outputs 8k to 8k+7.
- R3: With `wide` low, a line is complete after 40 accepted transfers of 4 bits. Transfer k fills outputs 4k to 4k+3. Only `din[3:0]` is used, and `din[7:4]` has no effect.
- R4: With `dir` low, output j of a group of width W takes data line W-1-j. With `dir` high, output j takes data line j.
- R5: A transfer is accepted only when `dclk` falls while the active enable input is low. A fall of `dclk` while that input is high captures nothing.
- R6: After the last group of a line is accepted, the enable output goes low. It stays low, and further transfers are ignored, until the next falling edge of `load`.
- R7: Output codes change only when `load` falls, `alt` changes or `disp_on` changes. Data being captured does not reach the outputs before the load.
- R8: A falling edge of `load` copies the captured line to the output latch. It clears the transfer count and drives the enable output high again. A transfer detected in the same cycle as that edge is dropped.
- R9: The code for each output is 2'b00 for alt=1 and bit=1, 2'b01 for alt=1 and bit=0, 2'b10 for alt=0 and bit=0, and 2'b11 for alt=0 and bit=1. Output i occupies `lvl[2i+1:2i]`, and output 0 is the lowest-numbered output.
- R10: While `disp_on` is low, every output code is 2'b11, whatever the data and alternation.
- R11: With `dir` low, `en1_i` is the enable input and pin 2 drives (`en2_oe`=1, `en1_oe`=0). With `dir` high the roles swap. Exactly one output-enable is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dclk | input | 1 | Data strobe; its falling edge captures one transfer |
| load | input | 1 | Line strobe; its falling edge latches the line |
| alt | input | 1 | Frame alternation phase |
| disp_on | input | 1 | Low forces every output to 2'b11 |
| wide | input | 1 | High selects 8-bit transfers, low selects 4-bit transfers |
| dir | input | 1 | Bit order and enable-pin role select |
| din | input | 8 | Parallel pixel data |
| en1_i | input | 1 | Enable pin 1, input side |
| en1_o | output | 1 | Enable pin 1, output value (active low) |
| en1_oe | output | 1 | Enable pin 1 drives when high |
| en2_i | input | 1 | Enable pin 2, input side |
| en2_o | output | 1 | Enable pin 2, output value (active low) |
| en2_oe | output | 1 | Enable pin 2 drives when high |
| lvl | output | 320 | Two-bit level code per output |

## Verification
The hardest state to reach from the ports is a completed line that still receives transfers, together with a gap in the enable chain in the middle of the same line. Both must leave the captured line untouched. The stimulus reaches this state by holding the active enable input high for a random number of transfers, then filling the line, and then sending extra transfers after completion. It does this under randomly chosen bus width and direction. After the next load, every output is compared against a model that only ever saw the accepted transfers.

// File: rtl/seg_drv_pkg.sv
// Package: level codes shared by the segment line driver.
// Assumes two-bit codes; the mapping follows the pixel bit and the phase.
package seg_drv_pkg;

    typedef enum logic [1:0] {
        LVL_SEL_HI   = 2'b00,
        LVL_DESEL_HI = 2'b01,
        LVL_DESEL_LO = 2'b10,
        LVL_SEL_LO   = 2'b11
    } lvl_e;

    // Pick the drive level of one output from its bit, the phase and the blanking input.
    function automatic logic [1:0] pick_level(input logic px, input logic phase, input logic show);
        lvl_e code;
        if (!show) begin
            code = LVL_SEL_LO;
        end else if (phase) begin
            code = px ? LVL_SEL_HI : LVL_DESEL_HI;
        end else begin
            code = px ? LVL_SEL_LO : LVL_DESEL_LO;
        end
        return code;
    endfunction

endpackage

// File: rtl/seg_edge_det.sv
// Falling-edge detector for N strobes sampled in the system clock domain.
// Assumes the strobes are already synchronous. The history resets low, so
// a strobe that is high at reset release gives no false edge.
module seg_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // Keep the last sampled value of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sig;
        end
    end

    assign fall = prev_q & ~sig;

endmodule

// File: rtl/seg_xfer_ctrl.sv
// Transfer sequencer: counts the groups accepted in the current line and
// decides when the line is full. Assumes the bus width does not change in
// the middle of a line. A load edge takes priority over a coincident transfer.
module seg_xfer_ctrl #(
    parameter int NUM_SEG  = 160,
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4,
    parameter int CW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_fall,
    input  logic          load_fall,
    input  logic          wide,
    input  logic          en_in_n,
    output logic          accept,
    output logic [CW-1:0] grp_idx,
    output logic          done
);

    localparam int WIDE_GROUPS   = NUM_SEG / WIDE_W;
    localparam int NARROW_GROUPS = NUM_SEG / NARROW_W;
    localparam logic [CW-1:0] LAST_WIDE   = CW'(WIDE_GROUPS - 1);
    localparam logic [CW-1:0] LAST_NARROW = CW'(NARROW_GROUPS - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [CW-1:0] last_idx;

    assign last_idx = wide ? LAST_WIDE : LAST_NARROW;
    assign accept   = cap_fall & ~en_in_n & ~done_q & ~load_fall;
    assign grp_idx  = cnt_q;
    assign done     = done_q;

    // Advance the group count on each accepted transfer; rearm on a load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (load_fall) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= last_idx) begin
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_line_buf.sv
// Capture buffer and output latch. Each bit has its own write decode, so a
// transfer writes its group in place and nothing shifts. Only the low
// NARROW_W data lines are used in narrow mode.
module seg_line_buf #(
    parameter int NUM_SEG  = 160,
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4,
    parameter int CW       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [CW-1:0]      grp_idx,
    input  logic               wide,
    input  logic               dir,
    input  logic [WIDE_W-1:0]  din,
    input  logic               load_fall,
    output logic [NUM_SEG-1:0] line_q
);

    logic [NUM_SEG-1:0] shadow_q;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam int WG = s / WIDE_W;
        localparam int WJ = s % WIDE_W;
        localparam int NG = s / NARROW_W;
        localparam int NJ = s % NARROW_W;

        logic hit;
        logic bitv;

        assign hit  = wide ? (grp_idx == CW'(WG)) : (grp_idx == CW'(NG));
        assign bitv = wide ? (dir ? din[WJ] : din[WIDE_W-1-WJ])
                           : (dir ? din[NJ] : din[NARROW_W-1-NJ]);

        // Write this bit when its group is the one being transferred.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[s] <= 1'b0;
            end else if (accept && hit) begin
                shadow_q[s] <= bitv;
            end
        end
    end

    // Copy the whole captured line to the display latch on a load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load_fall) begin
            line_q <= shadow_q;
        end
    end

endmodule

// File: rtl/seg_level_map.sv
// Level encoder: turns each latched bit into a two-bit drive code from the
// phase and blanking inputs. Purely combinational, one encoder per output.
module seg_level_map #(
    parameter int NUM_SEG = 160
) (
    input  logic [NUM_SEG-1:0]   line_q,
    input  logic                 phase,
    input  logic                 show,
    output logic [2*NUM_SEG-1:0] lvl
);

    import seg_drv_pkg::*;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_map
        assign lvl[2*s +: 2] = pick_level(line_q[s], phase, show);
    end

endmodule

// File: rtl/seg_line_driver.sv
// Top: cascadable segment line driver. It captures a line from a 4- or 8-bit
// bus, latches it on a load edge and drives level codes. Assumes all strobes
// are synchronous to clk. The enable pins are modelled as in/out/oe triples.
module seg_line_driver #(
    parameter int NUM_SEG  = 160,
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dclk,
    input  logic                 load,
    input  logic                 alt,
    input  logic                 disp_on,
    input  logic                 wide,
    input  logic                 dir,
    input  logic [WIDE_W-1:0]    din,
    input  logic                 en1_i,
    output logic                 en1_o,
    output logic                 en1_oe,
    input  logic                 en2_i,
    output logic                 en2_o,
    output logic                 en2_oe,
    output logic [2*NUM_SEG-1:0] lvl
);

    localparam int CW = $clog2(NUM_SEG / NARROW_W + 1);

    logic [1:0]         falls;
    logic               cap_fall;
    logic               load_fall;
    logic               en_in_n;
    logic               accept;
    logic [CW-1:0]      grp_idx;
    logic               done;
    logic [NUM_SEG-1:0] line_q;

    assign en_in_n   = dir ? en2_i : en1_i;
    assign cap_fall  = falls[0];
    assign load_fall = falls[1];

    assign en1_o  = ~done;
    assign en2_o  = ~done;
    assign en1_oe = dir;
    assign en2_oe = ~dir;

    seg_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({load, dclk}),
        .fall (falls)
    );

    seg_xfer_ctrl #(
        .NUM_SEG (NUM_SEG),
        .WIDE_W  (WIDE_W),
        .NARROW_W(NARROW_W),
        .CW      (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fall (cap_fall),
        .load_fall(load_fall),
        .wide     (wide),
        .en_in_n  (en_in_n),
        .accept   (accept),
        .grp_idx  (grp_idx),
        .done     (done)
    );

    seg_line_buf #(
        .NUM_SEG (NUM_SEG),
        .WIDE_W  (WIDE_W),
        .NARROW_W(NARROW_W),
        .CW      (CW)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .grp_idx  (grp_idx),
        .wide     (wide),
        .dir      (dir),
        .din      (din),
        .load_fall(load_fall),
        .line_q   (line_q)
    );

    seg_level_map #(.NUM_SEG(NUM_SEG)) u_map (
        .line_q(line_q),
        .phase (alt),
        .show  (disp_on),
        .lvl   (lvl)
    );

endmodule

// File: rtl/seg_line_driver_chk.sv
// Checker for seg_line_driver, watching its ports only. It is attached
// with the bind statement at the end of this file.
module seg_line_driver_chk #(
    parameter int NUM_SEG = 160
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load,
    input logic                 alt,
    input logic                 disp_on,
    input logic                 dir,
    input logic                 en1_o,
    input logic                 en1_oe,
    input logic                 en2_oe,
    input logic [2*NUM_SEG-1:0] lvl
);

    // R11: exactly one enable pin drives at a time.
    a_r11_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        en1_oe != en2_oe);

    // R11: with dir low, pin 2 is the driving pin.
    a_r11_dir_low_pin2: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> en2_oe);

    // R10: blanking forces every output code high.
    a_r10_blank_all: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (&lvl));

    // R6: a low enable output stays low until a load edge.
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!en1_o) && !($past(load, 2) && !$past(load))) |-> !en1_o);

    // R8: a load edge releases the enable output.
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load, 2) && !$past(load)) |-> en1_o);

    // R7: the outputs hold unless a load edge, alt or disp_on changes them.
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alt == $past(alt) && disp_on == $past(disp_on) &&
         !($past(load, 2) && !$past(load))) |-> (lvl == $past(lvl)));

endmodule

bind seg_line_driver seg_line_driver_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .alt    (alt),
    .disp_on(disp_on),
    .dir    (dir),
    .en1_o  (en1_o),
    .en1_oe (en1_oe),
    .en2_oe (en2_oe),
    .lvl    (lvl)
);

// File: tb/sim_seg_line_driver.sv
module sim_seg_line_driver;

    localparam int NS = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dclk = 1'b0;
    logic          load = 1'b0;
    logic          alt = 1'b1;
    logic          disp_on = 1'b1;
    logic          wide = 1'b1;
    logic          dir = 1'b0;
    logic [7:0]    din = '0;
    logic          en1_i = 1'b0;
    logic          en2_i = 1'b1;
    logic          en1_o, en1_oe, en2_o, en2_oe;
    logic [2*NS-1:0] lvl;

    int n_chk = 0;
    int n_bad = 0;

    logic [NS-1:0] m_buf = '0;
    logic [NS-1:0] m_lat = '0;
    int            m_cnt = 0;
    logic          m_done = 1'b0;

    always #5 clk = ~clk;

    seg_line_driver u0 (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .load(load), .alt(alt),
        .disp_on(disp_on), .wide(wide), .dir(dir), .din(din),
        .en1_i(en1_i), .en1_o(en1_o), .en1_oe(en1_oe),
        .en2_i(en2_i), .en2_o(en2_o), .en2_oe(en2_oe), .lvl(lvl)
    );

    function automatic logic [1:0] code_of(input logic b, input logic a, input logic d);
        if (!d) return 2'b11;
        if (a) return b ? 2'b00 : 2'b01;
        return b ? 2'b11 : 2'b10;
    endfunction

    function automatic logic [2*NS-1:0] exp_lvl(input logic [NS-1:0] lat, input logic a, input logic d);
        logic [2*NS-1:0] v;
        for (int i = 0; i < NS; i++) v[2*i +: 2] = code_of(lat[i], a, d);
        return v;
    endfunction

    task automatic chk_vec(input string req, input logic [2*NS-1:0] act, input logic [2*NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    // Enable output value read from the pin that currently drives (R11).
    function automatic logic eo_pin();
        return dir ? en1_o : en2_o;
    endfunction

    task automatic set_enable(input logic active_n);
        if (dir) begin en2_i = active_n; en1_i = 1'b1; end
        else     begin en1_i = active_n; en2_i = 1'b1; end
    endtask

    // One data strobe pulse and the model update that the requirements give (R2 R3 R4 R5 R6).
    task automatic xfer(input logic [7:0] d);
        int w;
        logic act_n;
        @(negedge clk); din = d; dclk = 1'b1;
        @(negedge clk); dclk = 1'b0;
        @(negedge clk);
        w = wide ? 8 : 4;
        act_n = dir ? en2_i : en1_i;
        if (!act_n && !m_done) begin
            for (int j = 0; j < w; j++)
                m_buf[m_cnt*w + j] = dir ? d[j] : d[w-1-j];
            m_cnt++;
            if (m_cnt == NS / w) m_done = 1'b1;
        end
    endtask

    task automatic do_load();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        m_lat = m_buf; m_cnt = 0; m_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_vec("R1 reset levels", lvl, {NS{2'b01}});
        chk_bit("R1 reset enable out", en2_o, 1'b1);
        chk_bit("R11 dir low pin2 drives", en2_oe, 1'b1);
        chk_bit("R11 dir low pin1 listens", en1_oe, 1'b0);

        // Directed R4: dir low, 8-bit, every transfer drives data line 0 only
        wide = 1'b1; dir = 1'b0; set_enable(1'b0);
        for (int k = 0; k < 20; k++) xfer(8'h01);
        chk_bit("R2 wide line full after 20", eo_pin(), 1'b0);
        do_load();
        chk_vec("R4 dir low reversed group", lvl, exp_lvl(m_lat, alt, disp_on));
        chk_bit("R4 output 7 selected", lvl[15:14] == 2'b00, 1'b1);
        chk_bit("R4 output 0 deselected", lvl[1:0] == 2'b01, 1'b1);

        // Directed R11/R5: dir high makes pin 2 the input; pin 1 low alone captures nothing
        dir = 1'b1; en1_i = 1'b0; en2_i = 1'b1;
        @(negedge clk);
        chk_bit("R11 dir high pin1 drives", en1_oe, 1'b1);
        chk_bit("R11 dir high pin2 listens", en2_oe, 1'b0);
        for (int k = 0; k < 45; k++) xfer(8'hFF);
        chk_bit("R5 wrong pin blocks capture", eo_pin(), 1'b1);

        // Random lines
        for (int ln = 0; ln < 30; ln++) begin
            int n;
            int gap;
            wide = 1'($urandom % 2);
            dir  = 1'($urandom % 2);
            n = wide ? 20 : 40;
            gap = (ln % 3 == 0) ? 0 : int'($urandom % 4);
            set_enable(1'b1);
            for (int k = 0; k < gap; k++) xfer(8'($urandom));
            chk_bit("R5 disabled transfers ignored", eo_pin(), 1'b1);
            set_enable(1'b0);
            for (int k = 0; k < n; k++) begin
                xfer(8'($urandom));
                chk_bit(wide ? "R6 R2 enable out after wide transfer" : "R6 R3 enable out after narrow transfer",
                        eo_pin(), ~m_done);
            end
            for (int k = 0; k < 2; k++) xfer(8'($urandom));
            chk_bit("R6 stays low after extra transfers", eo_pin(), 1'b0);
            alt = 1'b1; disp_on = 1'b1;
            @(negedge clk);
            chk_vec("R7 outputs hold old line before load", lvl, exp_lvl(m_lat, 1'b1, 1'b1));
            do_load();
            chk_bit("R8 enable out released by load", eo_pin(), 1'b1);
            chk_vec(wide ? "R2 R4 wide line after load" : "R3 R4 narrow line after load",
                    lvl, exp_lvl(m_lat, 1'b1, 1'b1));
            alt = 1'b0;
            @(negedge clk);
            chk_vec("R9 alt low levels", lvl, exp_lvl(m_lat, 1'b0, 1'b1));
            disp_on = 1'b0;
            @(negedge clk);
            chk_vec("R10 blank forces all high", lvl, {NS{2'b11}});
            disp_on = 1'b1; alt = 1'b1;
        end

        // Directed R8: a transfer whose edge coincides with the load edge is dropped
        wide = 1'b1; dir = 1'b0; set_enable(1'b0);
        @(negedge clk); din = 8'hFF; dclk = 1'b1; load = 1'b1;
        @(negedge clk); dclk = 1'b0; load = 1'b0;
        @(negedge clk);
        m_lat = m_buf; m_cnt = 0; m_done = 1'b0;
        for (int k = 0; k < 19; k++) xfer(8'h00);
        chk_bit("R8 coincident transfer dropped", eo_pin(), 1'b1);
        xfer(8'h00);
        chk_bit("R8 count restarted at zero", eo_pin(), 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule